// File: doc/BRIEF.md
# Time-Shared Gaussian Pyramid Engine

This block turns a raster stream of 8-bit pixels into a three-level Gaussian pyramid. One 3x3 convolution unit does all the filtering. A fixed schedule of 21 slots hands that unit to the coarsest level in one slot, to the middle level in four slots and to the finest level in sixteen slots, and then the schedule repeats. Each level keeps a small store of four image rows. The 3x3 window is read from that store with edge pixels repeated at the frame borders. A multiplexer picks the window of the level that owns the current slot and feeds it to the shared filter.

Level 0 filters the incoming image at full resolution. Each level-0 result whose row and column are both even is also written into the level-1 store, and level 1 feeds level 2 the same way. So the data between levels never leaves the block. Every filtered pixel leaves on a single tagged output stream that carries the level number and the pixel's coordinates in that level's grid. The input uses a valid/ready handshake. The output has no back-pressure and is valid for exactly one cycle per result.

Top module: `ts_gauss_pyramid`

## Requirements
- R1: An interior level-0 output equals (sum of w(dr)*w(dc)*p(r+dr,c+dc) over dr,dc in {-1,0,1} + 8) >> 4, where w(0)=2 and w(+-1)=1, and p is the input frame.
- R2: The input image of level L+1 is the level-L output at even row and even column. Level 1 and level 2 outputs follow R1 on that image. Each frame yields exactly W*H, W*H/4 and W*H/16 outputs on levels 0, 1 and 2.
- R3: `out_level` carries 0, 1 or 2 for levels 0, 1 and 2. On each level, results appear in raster order (row-major, column 0 first), with `out_row` and `out_col` giving the position in that level's grid.
- R4: The slot counter starts at 0 when reset is released. Slot 0 serves level 2, slots 1 to 4 serve level 1, and slots 5 to 20 serve level 0, and then the counter wraps to 0. A result issued in slot s appears on the output in the cycle after that slot, tagged with the level that owns s.
- R5: `in_ready` is high only while level 0 can store a pixel without overwriting rows that a pending window still needs. Once a whole frame has been accepted, the first pixel of the next frame is accepted only after the last level-0 result of the current frame has appeared.
- R6: A slot whose level has no complete window is a bubble with `out_valid` low. With no input, no output appears.
- R7: While reset is held and right after it is released, `out_valid` is low and `in_ready` is high.
- R8: The filter result saturates at 255, so a frame of 255 gives 255 at every position on every level.
- R9: At frame borders, pixels outside the image take the value of the nearest edge pixel (clamped row and column), on every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Level 0 can take a pixel this cycle |
| in_pix | input | 8 | Input pixel, raster order |
| out_valid | output | 1 | Output result valid for this cycle |
| out_level | output | 2 | Pyramid level of the result |
| out_row | output | $clog2(IMG_H) | Row of the result in its level's grid |
| out_col | output | $clog2(IMG_W) | Column of the result in its level's grid |
| out_pix | output | 8 | Filtered pixel |

## Verification
Each level keeps its own write and window counters. If one of them drifts, the damage shows at the ports within one schedule round. A slipped window counter puts a result out of raster order or gives it the wrong coordinates. A bad row slot or a bad border clamp gives a wrong pixel value. A bad hand-off between levels corrupts the level 1 or level 2 values one or two rows later. A wrong slot decode shows up in the first output after it, because that output carries a level tag that does not match the slot's cycle. An overly permissive `in_ready` lets the next frame in before the previous frame's last level-0 result has left the block, or it overwrites a stored row, which then shows as wrong values.

// File: rtl/tsgp_pkg.sv
package tsgp_pkg;
    localparam int NUM_LVL  = 3;
    localparam int PIX_W    = 8;
    localparam int SLOTS_L2 = 1;
    localparam int SLOTS_L1 = 4;
    localparam int SLOTS_L0 = 16;
    localparam int SLOTS    = SLOTS_L2 + SLOTS_L1 + SLOTS_L0;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int WIN_W    = 9 * PIX_W;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [1:0]        lvl_t;
    typedef logic [SLOT_W-1:0] slot_t;

    // Coarsest level first, then the middle level, then the finest level.
    function automatic lvl_t slot_level(input slot_t s);
        if (int'(s) < SLOTS_L2) begin
            return 2'd2;
        end else if (int'(s) < SLOTS_L2 + SLOTS_L1) begin
            return 2'd1;
        end
        return 2'd0;
    endfunction
endpackage

// File: rtl/tsgp_slot_sched.sv
module tsgp_slot_sched
    import tsgp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_t slot,
    output lvl_t  slot_lvl
);
    typedef struct packed {
        slot_t slot;
    } sched_t;

    sched_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (int'(st_q.slot) == SLOTS - 1) begin
            st_d.slot = '0;
        end else begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot     = st_q.slot;
    assign slot_lvl = slot_level(st_q.slot);

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.slot) < SLOTS); // R4
endmodule

// File: rtl/tsgp_line_store.sv
module tsgp_line_store
    import tsgp_pkg::*;
#(
    parameter int W_L = 16,
    parameter int H_L = 12,
    parameter int ORW = 4,
    parameter int OCW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  pix_t             wr_pix,
    output logic             wr_ok,
    input  logic             adv,
    output logic             win_ready,
    output logic [WIN_W-1:0] win,
    output logic [ORW-1:0]   win_row,
    output logic [OCW-1:0]   win_col
);
    localparam int CW    = $clog2(W_L);
    localparam int RW    = $clog2(H_L);
    localparam int RWX   = (RW < 2) ? 2 : RW;
    localparam int FRM   = W_L * H_L;
    localparam int NW    = $clog2(FRM + 1);
    localparam int ROWS  = 4;
    localparam int AHEAD = (ROWS - 1) * W_L;

    typedef struct packed {
        logic [NW-1:0] n;
        logic [NW-1:0] p;
        logic [RW-1:0] wr_r;
        logic [CW-1:0] wr_c;
        logic [RW-1:0] pr;
        logic [CW-1:0] pc;
    } lstate_t;

    lstate_t st_d, st_q;
    pix_t    mem_q [ROWS][W_L];

    logic [RW-1:0] rsel [3];
    logic [CW-1:0] csel [3];
    int            need;

    function automatic logic [1:0] row_slot(input logic [RW-1:0] r);
        logic [RWX-1:0] x;
        x = RWX'(r);
        return x[1:0];
    endfunction

    // Window taps with replicated borders.
    always_comb begin
        rsel[0] = (st_q.pr == '0) ? st_q.pr : st_q.pr - 1'b1;
        rsel[1] = st_q.pr;
        rsel[2] = (int'(st_q.pr) == H_L - 1) ? st_q.pr : st_q.pr + 1'b1;
        csel[0] = (st_q.pc == '0) ? st_q.pc : st_q.pc - 1'b1;
        csel[1] = st_q.pc;
        csel[2] = (int'(st_q.pc) == W_L - 1) ? st_q.pc : st_q.pc + 1'b1;
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                win[(i*3+j)*PIX_W +: PIX_W] = mem_q[row_slot(rsel[i])][csel[j]];
            end
        end
        need      = int'(rsel[2]) * W_L + int'(csel[2]);
        win_ready = (int'(st_q.p) < FRM) && (int'(st_q.n) > need);
        wr_ok     = (int'(st_q.n) < FRM) &&
                    ((int'(st_q.n) < ROWS * W_L) ||
                     (int'(st_q.p) + AHEAD >= int'(st_q.n) + 2));
    end

    always_comb begin
        st_d = st_q;
        if ((int'(st_q.n) == FRM) && (int'(st_q.p) == FRM)) begin
            st_d.n = '0;
            st_d.p = '0;
        end else begin
            if (wr_en) begin
                st_d.n = st_q.n + 1'b1;
                if (int'(st_q.wr_c) == W_L - 1) begin
                    st_d.wr_c = '0;
                    st_d.wr_r = (int'(st_q.wr_r) == H_L - 1) ? '0 : st_q.wr_r + 1'b1;
                end else begin
                    st_d.wr_c = st_q.wr_c + 1'b1;
                end
            end
            if (adv) begin
                st_d.p = st_q.p + 1'b1;
                if (int'(st_q.pc) == W_L - 1) begin
                    st_d.pc = '0;
                    st_d.pr = (int'(st_q.pr) == H_L - 1) ? '0 : st_q.pr + 1'b1;
                end else begin
                    st_d.pc = st_q.pc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[row_slot(st_q.wr_r)][st_q.wr_c] <= wr_pix;
        end
    end

    assign win_row = ORW'(st_q.pr);
    assign win_col = OCW'(st_q.pc);

    AST_WRITE_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_ok); // R5
    AST_WINDOW_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> win_ready); // R6
    AST_WINDOW_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.p <= st_q.n); // R6
endmodule

// File: rtl/tsgp_conv3.sv
module tsgp_conv3
    import tsgp_pkg::*;
#(
    parameter int K_EDGE = 1,
    parameter int K_MID  = 2,
    parameter int SHIFT  = 4
) (
    input  logic [WIN_W-1:0] win,
    output pix_t             pix
);
    localparam int RND  = 1 << (SHIFT - 1);
    localparam int PMAX = (1 << PIX_W) - 1;

    int acc;
    int res;

    function automatic int tap_wt(input int k);
        return (k == 1) ? K_MID : K_EDGE;
    endfunction

    always_comb begin
        acc = 0;
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                acc = acc + tap_wt(i) * tap_wt(j) * int'(win[(i*3+j)*PIX_W +: PIX_W]);
            end
        end
        res = (acc + RND) >>> SHIFT;
        pix = (res > PMAX) ? pix_t'(PMAX) : pix_t'(res);
    end
endmodule

// File: rtl/ts_gauss_pyramid.sv
module ts_gauss_pyramid
    import tsgp_pkg::*;
#(
    parameter int IMG_W  = 16,
    parameter int IMG_H  = 12,
    parameter int K_EDGE = 1,
    parameter int K_MID  = 2,
    parameter int SHIFT  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [PIX_W-1:0]         in_pix,
    output logic                     out_valid,
    output logic [1:0]               out_level,
    output logic [$clog2(IMG_H)-1:0] out_row,
    output logic [$clog2(IMG_W)-1:0] out_col,
    output logic [PIX_W-1:0]         out_pix
);
    localparam int RW0 = $clog2(IMG_H);
    localparam int CW0 = $clog2(IMG_W);

    typedef struct packed {
        logic           valid;
        lvl_t           level;
        logic [RW0-1:0] row;
        logic [CW0-1:0] col;
        pix_t           pix;
    } out_t;

    out_t st_d, st_q;

    logic             wr_en_a   [NUM_LVL];
    pix_t             wr_pix_a  [NUM_LVL];
    logic             wr_ok_a   [NUM_LVL];
    logic             adv_a     [NUM_LVL];
    logic             ready_a   [NUM_LVL];
    logic [WIN_W-1:0] win_a     [NUM_LVL];
    logic [RW0-1:0]   row_a     [NUM_LVL];
    logic [CW0-1:0]   col_a     [NUM_LVL];

    slot_t            slot;
    lvl_t             sel;
    logic             rdy_sel;
    logic [WIN_W-1:0] win_sel;
    logic [RW0-1:0]   row_sel;
    logic [CW0-1:0]   col_sel;
    logic             keep;
    logic             down_ok;
    logic             issue;
    pix_t             pe_pix;

    tsgp_slot_sched u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (slot),
        .slot_lvl (sel)
    );

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        tsgp_line_store #(
            .W_L (IMG_W >> l),
            .H_L (IMG_H >> l),
            .ORW (RW0),
            .OCW (CW0)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en_a[l]),
            .wr_pix    (wr_pix_a[l]),
            .wr_ok     (wr_ok_a[l]),
            .adv       (adv_a[l]),
            .win_ready (ready_a[l]),
            .win       (win_a[l]),
            .win_row   (row_a[l]),
            .win_col   (col_a[l])
        );
    end

    tsgp_conv3 #(
        .K_EDGE (K_EDGE),
        .K_MID  (K_MID),
        .SHIFT  (SHIFT)
    ) u_pe (
        .win (win_sel),
        .pix (pe_pix)
    );

    // Timing multiplexer: the slot owner's window drives the shared filter.
    always_comb begin
        rdy_sel = 1'b0;
        win_sel = '0;
        row_sel = '0;
        col_sel = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (sel == lvl_t'(l)) begin
                rdy_sel = ready_a[l];
                win_sel = win_a[l];
                row_sel = row_a[l];
                col_sel = col_a[l];
            end
        end
        keep = !row_sel[0] && !col_sel[0];
        case (sel)
            2'd0:    down_ok = wr_ok_a[1];
            2'd1:    down_ok = wr_ok_a[2];
            default: down_ok = 1'b1;
        endcase
        issue = rdy_sel && (!keep || down_ok);
        for (int l = 0; l < NUM_LVL; l++) begin
            adv_a[l] = issue && (sel == lvl_t'(l));
        end
        wr_en_a[0]  = in_valid && wr_ok_a[0];
        wr_pix_a[0] = in_pix;
        wr_en_a[1]  = issue && keep && (sel == 2'd0);
        wr_pix_a[1] = pe_pix;
        wr_en_a[2]  = issue && keep && (sel == 2'd1);
        wr_pix_a[2] = pe_pix;
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = issue;
        if (issue) begin
            st_d.level = sel;
            st_d.row   = row_sel;
            st_d.col   = col_sel;
            st_d.pix   = pe_pix;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = wr_ok_a[0];
    assign out_valid = st_q.valid;
    assign out_level = st_q.level;
    assign out_row   = st_q.row;
    assign out_col   = st_q.col;
    assign out_pix   = st_q.pix;

    AST_OUT_FOLLOWS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.level == slot_level($past(slot)))); // R4
    AST_LEVEL_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (int'(st_q.level) < NUM_LVL)); // R3
endmodule

// File: tb/ts_gauss_pyramid_bench.sv
module ts_gauss_pyramid_bench;
    localparam int W  = 16;
    localparam int H  = 12;
    localparam int NF = 4;
    localparam int SL = 21;
    localparam int CW = $clog2(W);
    localparam int RW = $clog2(H);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_pix = 8'd0;
    logic          out_valid;
    logic [1:0]    out_level;
    logic [RW-1:0] out_row;
    logic [CW-1:0] out_col;
    logic [7:0]    out_pix;

    always #4 clk = ~clk;

    ts_gauss_pyramid #(.IMG_W(W), .IMG_H(H)) u_ts_gauss_pyramid (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_level (out_level),
        .out_row   (out_row),
        .out_col   (out_col),
        .out_pix   (out_pix)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int img [NF][H][W];
    int exp_r [3];
    int exp_c [3];
    int frm [3];
    int seen [3];
    int last0 [NF];
    int first_acc [NF];
    int low_cnt = 0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int lvl_of_slot(input int s);
        if (s == 0) return 2;
        if (s <= 4) return 1;
        return 0;
    endfunction

    function automatic int clampi(input int v, input int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    // Reference filter built from R1, R2, R8, R9.
    function automatic int filt(input int lvl, input int f, input int r, input int c);
        int wl, hl, acc, rr, cc, v, res;
        wl  = W >> lvl;
        hl  = H >> lvl;
        acc = 0;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                rr = clampi(r + dr, hl - 1);
                cc = clampi(c + dc, wl - 1);
                if (lvl == 0) v = img[f][rr][cc];
                else          v = filt(lvl - 1, f, 2 * rr, 2 * cc);
                acc += ((dr == 0) ? 2 : 1) * ((dc == 0) ? 2 : 1) * v;
            end
        end
        res = (acc + 8) >> 4;
        return (res > 255) ? 255 : res;
    endfunction

    always @(negedge clk) begin
        int l, e, wl, hl;
        bit border;
        if (rst_n && out_valid) begin
            l = int'(out_level);
            check(l == lvl_of_slot((cyc - 1) % SL), "R4", "level tag vs slot", l,
                  lvl_of_slot((cyc - 1) % SL));
            if (l > 2) begin
                check(1'b0, "R3", "level tag range", l, 2);
            end else begin
                wl = W >> l;
                hl = H >> l;
                check(int'(out_row) == exp_r[l] && int'(out_col) == exp_c[l], "R3",
                      "raster position row*64+col", int'(out_row) * 64 + int'(out_col),
                      exp_r[l] * 64 + exp_c[l]);
                if (frm[l] < NF) begin
                    e = filt(l, frm[l], exp_r[l], exp_c[l]);
                    border = (exp_r[l] == 0) || (exp_r[l] == hl - 1) ||
                             (exp_c[l] == 0) || (exp_c[l] == wl - 1);
                    if (border)      check(int'(out_pix) == e, "R9", "border pixel", int'(out_pix), e);
                    else if (l == 0) check(int'(out_pix) == e, "R1", "level0 pixel", int'(out_pix), e);
                    else             check(int'(out_pix) == e, "R2", "coarse pixel", int'(out_pix), e);
                    if (frm[l] == 1) check(int'(out_pix) == 255, "R8", "saturated flat", int'(out_pix), 255);
                end else begin
                    check(1'b0, "R2", "output beyond last frame", l, -1);
                end
                seen[l]++;
                exp_c[l]++;
                if (exp_c[l] == wl) begin
                    exp_c[l] = 0;
                    exp_r[l]++;
                    if (exp_r[l] == hl) begin
                        exp_r[l] = 0;
                        if (l == 0 && frm[0] < NF) last0[frm[0]] = cyc;
                        frm[l]++;
                    end
                end
            end
        end
    end

    task automatic drive_frame(input int f, input int dens);
        int idx;
        bit v;
        idx = 0;
        while (idx < W * H) begin
            @(negedge clk);
            v = (($urandom % 100) < dens);
            in_valid = v;
            in_pix = 8'(img[f][idx / W][idx % W]);
            #1;
            if (v && in_ready) begin
                if (idx == 0) first_acc[f] = cyc + 1;
                idx++;
            end else if (v) begin
                low_cnt++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        int total;
        void'($urandom(32'd2024));
        for (int i = 0; i < 3; i++) begin
            exp_r[i] = 0; exp_c[i] = 0; frm[i] = 0; seen[i] = 0;
        end
        for (int f = 0; f < NF; f++) begin
            last0[f] = 0;
            first_acc[f] = 0;
            for (int r = 0; r < H; r++) begin
                for (int c = 0; c < W; c++) begin
                    case (f)
                        1:       img[f][r][c] = 255;
                        2:       img[f][r][c] = ((r + c) % 2 == 1) ? 255 : 0;
                        default: img[f][r][c] = int'($urandom % 256);
                    endcase
                end
            end
        end
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R7", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R7", "in_ready after reset", int'(in_ready), 1);
        repeat (60) @(negedge clk);
        check(seen[0] + seen[1] + seen[2] == 0, "R6", "outputs with no input",
              seen[0] + seen[1] + seen[2], 0);
        drive_frame(0, 100);
        drive_frame(1, 100);
        drive_frame(2, 100);
        drive_frame(3, 45);
        total = NF * (W * H + (W * H) / 4 + (W * H) / 16);
        while (seen[0] + seen[1] + seen[2] < total) @(negedge clk);
        repeat (60) @(negedge clk);
        for (int l = 0; l < 3; l++) begin
            check(seen[l] == NF * ((W * H) >> (2 * l)), "R2", "results per level",
                  seen[l], NF * ((W * H) >> (2 * l)));
        end
        check(low_cnt > 0, "R5", "in_ready deasserted under full-rate input", low_cnt, 1);
        for (int f = 1; f < NF; f++) begin
            check(first_acc[f] > last0[f - 1], "R5", "next frame held until level0 drained",
                  first_acc[f], last0[f - 1] + 1);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", seen[0] + seen[1] + seen[2],
                 NF * (W * H + (W * H) / 4 + (W * H) / 16));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule